// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory

A single-ported, clocked memory with a two-bit burst sequencer and a registered read path. Each word is made of byte lanes of nine bits: eight data bits and one parity bit. Address, chip selects, both address strobes, the advance input, the write controls and the write data are all taken on the rising clock edge. Output enable and the snooze input act without the clock.

A burst begins on one of two strobes. The processor strobe always begins a read. The controller strobe begins a read or a write, depending on the write controls. While no strobe is low, the advance input either steps the burst or holds it at the current address. Read data shows up one cycle after the edge that took the read, and the drive is dropped after one more cycle unless another read follows. The data path is split into `d_in`, `q_out` and a drive enable `q_en`, so an outer pad ring can build the shared bus from them.

Top module: `pipe_burst_ram`

## Requirements
- R1: When `strb_p_n` is low and `cen_n` is low, the edge loads `addr` and performs a read whatever the write controls show. When `cen_n` is high, `strb_p_n` has no effect: the cycle behaves as if both strobes were high.
- R2: When `strb_c_n` is low (and the R1 start does not apply), the edge behaves as follows. With `cen_n` low it loads `addr` and performs a write if the write controls ask for one, and a read otherwise. With `cen_n` high it deselects the device: no access, and the burst ends.
- R3: The two secondary selects are looked at only on a loading edge. If `cen2` is low or `cen2_n` is high, that edge makes no access and ends the burst. Later edges with both strobes high then do nothing until a new start.
- R4: A write is requested when `gwr_n` is low, which writes all lanes. It is also requested when `bwe_n` is low and some bit of `lane_n` is low; then only lanes whose `lane_n` bit is low are written. Lane l is word bits [9l+8:9l], and its parity bit is bit 9l+8. `lane_n` bits are ignored while `bwe_n` is high.
- R5: Suppose the edge after a processor-strobe start has both strobes high, `adv_n` high and a write requested. That edge writes the address loaded by the start.
- R6: With both strobes high during an active burst, `adv_n` low steps to the next burst address and `adv_n` high holds the current one. The access follows the write controls, and the chip selects are not looked at. The low two address bits are the base XOR a count for interleaved order (`lin_mode` low at the start). They are the base plus the count, modulo 4, for linear order (`lin_mode` high at the start). The upper bits stay fixed.
- R7: Data for a read taken at edge k appears on `q_out` with `q_en` high from just after edge k+1 until edge k+2.
- R8: If the access at edge k+1 is not a read, `q_en` is low after edge k+2. Back-to-back reads keep `q_en` high.
- R9: `q_en` is low at any time `oe_n` is high, without waiting for a clock. It is also low while the inputs present a write, whatever `oe_n` is.
- R10: `q_en` is low while `snooze` is high. Consider the rising edges at which `snooze` is sampled high: from the third one on, all other inputs are ignored. The first two rising edges at which it is sampled low after that are also ignored. Stored data is kept throughout.
- R11: A synchronous `rst` drops `q_en` and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | External word address |
| cen_n | input | 1 | Primary chip select, active low |
| cen2 | input | 1 | Secondary chip select, active high |
| cen2_n | input | 1 | Secondary chip select, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| snooze | input | 1 | Low-power hold, active high, asynchronous |
| d_in | input | 9*LANES | Write data with parity |
| q_out | output | 9*LANES | Read data with parity |
| q_en | output | 1 | Drive enable for `q_out` |

## Verification
The bench walks every base offset in both burst orders, mixing suspends and chip-select changes into continue cycles. A wrong order or a sequencer that samples the selects would return the wrong word. It writes lane masks at many addresses and reads them back, so a lane enable that leaves its parity bit out, or a write taken on `bwe_n` alone, shows up as corrupted data. Processor-strobe starts are made with the write controls asserted; a design that writes on such a start, or puts the follow-on write somewhere other than the loaded address, fails the read-back. Deselects, mid-burst reset and the snooze entry and exit windows are checked cycle by cycle on `q_en`. A late drive turn-off, or a write that slips through the ignore window, is therefore caught.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    // one lane: 8 data bits and a parity bit in the top position
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        CY_NONE  = 2'd0,
        CY_READ  = 2'd1,
        CY_WRITE = 2'd2
    } cyc_e;

    // decoded action for the current edge
    typedef struct packed {
        logic load;   // take a new external address
        logic step;   // bump the burst count
        logic live;   // burst state after this edge
        cyc_e kind;   // access performed at this edge
    } dec_t;

endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
    import pbr_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             gate,
    input  logic             active,
    input  logic             strb_p_n,
    input  logic             strb_c_n,
    input  logic             cen_n,
    input  logic             cen2,
    input  logic             cen2_n,
    input  logic             adv_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_n,
    output dec_t             dec,
    output logic [LANES-1:0] wmask
);

    logic [LANES-1:0] req_mask;
    logic             want_wr;
    logic             sel_ok;

    always_comb begin
        req_mask = !gwr_n ? '1 : (!bwe_n ? ~lane_n : '0);
        want_wr  = |req_mask;
        sel_ok   = cen2 & ~cen2_n;

        dec      = '0;
        dec.live = active;

        if (!gate) begin
            if (!strb_p_n && !cen_n) begin
                // processor start: always a read
                dec.load = 1'b1;
                dec.live = sel_ok;
                dec.kind = sel_ok ? CY_READ : CY_NONE;
            end else if (!strb_c_n) begin
                if (cen_n) begin
                    dec.live = 1'b0;
                end else begin
                    dec.load = 1'b1;
                    dec.live = sel_ok;
                    if (sel_ok)
                        dec.kind = want_wr ? CY_WRITE : CY_READ;
                end
            end else if (active) begin
                // continue or suspend, selects not looked at
                dec.step = ~adv_n;
                dec.kind = want_wr ? CY_WRITE : CY_READ;
            end
        end

        wmask = (dec.kind == CY_WRITE) ? req_mask : '0;
    end

endmodule

// File: rtl/pbr_seq.sv
module pbr_seq #(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ext_addr,
    input  logic          lin_in,
    output logic [AW-1:0] cur_addr
);

    logic [AW-1:0] base_q, base_d;
    logic [BW-1:0] cnt_q, cnt_d;
    logic          lin_q, lin_d;
    logic [BW-1:0] low;

    always_comb begin
        base_d = load ? ext_addr : base_q;
        lin_d  = load ? lin_in : lin_q;
        cnt_d  = load ? '0 : (step ? cnt_q + BW'(1) : cnt_q);
        low    = lin_d ? (base_d[BW-1:0] + cnt_d) : (base_d[BW-1:0] ^ cnt_d);
    end

    assign cur_addr = {base_d[AW-1:BW], low};

    always_ff @(posedge clk) begin
        base_q <= base_d;
        cnt_q  <= cnt_d;
        lin_q  <= lin_d;
    end

endmodule

// File: rtl/pbr_array.sv
module pbr_array
    import pbr_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        wmask,
    input  logic                    rd,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wmask[l])
                cells[addr] <= wdata[l*LANE_W +: LANE_W];
            if (rd)
                lane_q <= cells[addr];
        end

        assign rdata[l*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/pipe_burst_ram.sv
module pipe_burst_ram
    import pbr_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int BW    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           addr,
    input  logic                    cen_n,
    input  logic                    cen2,
    input  logic                    cen2_n,
    input  logic                    strb_p_n,
    input  logic                    strb_c_n,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    lin_mode,
    input  logic                    oe_n,
    input  logic                    snooze,
    input  logic [LANES*LANE_W-1:0] d_in,
    output logic [LANES*LANE_W-1:0] q_out,
    output logic                    q_en
);

    localparam int WW = LANES * LANE_W;

    logic             zz_s1, zz_s2;
    logic             active_q;
    logic             v1_q, v2_q;
    dec_t             dec;
    cyc_e             cur_kind;
    logic [LANES-1:0] wmask;
    logic [AW-1:0]    cur_addr;
    logic [WW-1:0]    rdata;
    logic [WW-1:0]    out_q;

    pbr_decode #(.LANES(LANES)) u_dec (
        .gate     (zz_s2),
        .active   (active_q),
        .strb_p_n (strb_p_n),
        .strb_c_n (strb_c_n),
        .cen_n    (cen_n),
        .cen2     (cen2),
        .cen2_n   (cen2_n),
        .adv_n    (adv_n),
        .gwr_n    (gwr_n),
        .bwe_n    (bwe_n),
        .lane_n   (lane_n),
        .dec      (dec),
        .wmask    (wmask)
    );

    assign cur_kind = dec.kind;

    pbr_seq #(.AW(AW), .BW(BW)) u_seq (
        .clk      (clk),
        .load     (dec.load),
        .step     (dec.step),
        .ext_addr (addr),
        .lin_in   (lin_mode),
        .cur_addr (cur_addr)
    );

    pbr_array #(.AW(AW), .LANES(LANES)) u_arr (
        .clk   (clk),
        .addr  (cur_addr),
        .wmask (wmask),
        .rd    (cur_kind == CY_READ),
        .wdata (d_in),
        .rdata (rdata)
    );

    // snooze is brought in through two flops before it gates the inputs
    always_ff @(posedge clk) begin
        if (rst) begin
            zz_s1    <= 1'b0;
            zz_s2    <= 1'b0;
            active_q <= 1'b0;
            v1_q     <= 1'b0;
            v2_q     <= 1'b0;
        end else begin
            zz_s1    <= snooze;
            zz_s2    <= zz_s1;
            active_q <= dec.live;
            v1_q     <= (cur_kind == CY_READ);
            v2_q     <= v1_q;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= rdata;
    end

    assign q_out = out_q;
    assign q_en  = v2_q & ~oe_n & ~snooze & (cur_kind != CY_WRITE);

endmodule

// File: rtl/pbr_checker.sv
module pbr_checker
    import pbr_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             snooze,
    input logic             oe_n,
    input logic             q_en,
    input logic             strb_p_n,
    input logic             cen_n,
    input logic             gwr_n,
    input logic             gate,
    input cyc_e             kind,
    input logic [LANES-1:0] wmask
);

    p_reset_quiet_r11: assert property (@(posedge clk) rst |=> !q_en);

    p_snooze_hiz_r10: assert property (@(posedge clk) disable iff (rst)
        snooze |-> !q_en);

    p_gate_idle_r10: assert property (@(posedge clk) disable iff (rst)
        gate |-> (kind == CY_NONE && wmask == '0));

    p_oe_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !q_en);

    p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
        q_en |-> $past(kind == CY_READ, 2));

    p_single_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        (kind != CY_READ) |=> ##1 !q_en);

    p_pstart_reads_r1: assert property (@(posedge clk) disable iff (rst)
        (!gate && !strb_p_n && !cen_n) |-> (kind != CY_WRITE && wmask == '0));

    p_full_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == CY_WRITE && !gwr_n) |-> (&wmask));

endmodule

bind pipe_burst_ram pbr_checker #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .snooze   (snooze),
    .oe_n     (oe_n),
    .q_en     (q_en),
    .strb_p_n (strb_p_n),
    .cen_n    (cen_n),
    .gwr_n    (gwr_n),
    .gate     (zz_s2),
    .kind     (cur_kind),
    .wmask    (wmask)
);

// File: tb/pipe_burst_ram_test.sv
module pipe_burst_ram_test;
    import pbr_pkg::*;

    localparam int AW    = 6;
    localparam int LANES = 2;
    localparam int BW    = 2;
    localparam int W     = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [AW-1:0]    addr = '0;
    logic             cen_n = 1'b0, cen2 = 1'b1, cen2_n = 1'b0;
    logic             strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
    logic             gwr_n = 1'b1, bwe_n = 1'b1;
    logic [LANES-1:0] lane_n = '1;
    logic             lin_mode = 1'b0, oe_n = 1'b0, snooze = 1'b0;
    logic [W-1:0]     d_in = '0;
    logic [W-1:0]     q_out;
    logic             q_en;

    pipe_burst_ram #(.AW(AW), .LANES(LANES), .BW(BW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .cen_n(cen_n), .cen2(cen2), .cen2_n(cen2_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .gwr_n(gwr_n),
        .bwe_n(bwe_n), .lane_n(lane_n), .lin_mode(lin_mode), .oe_n(oe_n),
        .snooze(snooze), .d_in(d_in), .q_out(q_out), .q_en(q_en)
    );

    int checks = 0;
    int errors = 0;

    // reference state, built from the requirements
    logic [W-1:0]  ref_mem [DEPTH];
    logic          m_act = 1'b0, m_lin = 1'b0, g1 = 1'b0, g2 = 1'b0;
    logic          s1v = 1'b0, s2v = 1'b0;
    logic [W-1:0]  s1d = '0, s2d = '0;
    logic [AW-1:0] m_base = '0;
    logic [BW-1:0] m_cnt = '0;

    function automatic logic [W-1:0] pat(int a, int s);
        return W'(a * 97 + s * 1237 + 19);
    endfunction

    // 0 none, 1 read, 2 write for the inputs now applied
    function automatic int kind_now();
        logic wr;
        logic sel;
        wr  = !gwr_n || (!bwe_n && lane_n != '1);
        sel = cen2 && !cen2_n;
        if (g2) return 0;
        if (!strb_p_n && !cen_n) return sel ? 1 : 0;
        if (!strb_c_n) return (!cen_n && sel) ? (wr ? 2 : 1) : 0;
        if (m_act) return wr ? 2 : 1;
        return 0;
    endfunction

    task automatic model_edge();
        int               k;
        logic [LANES-1:0] msk;
        logic [BW-1:0]    lo;
        logic [AW-1:0]    ea;
        k   = kind_now();
        msk = !gwr_n ? '1 : (!bwe_n ? ~lane_n : '0);
        if (!g2) begin
            if (!strb_p_n && !cen_n) begin
                m_base = addr; m_cnt = '0; m_lin = lin_mode; m_act = cen2 && !cen2_n;
            end else if (!strb_c_n) begin
                if (cen_n) m_act = 1'b0;
                else begin
                    m_base = addr; m_cnt = '0; m_lin = lin_mode; m_act = cen2 && !cen2_n;
                end
            end else if (m_act && !adv_n) begin
                m_cnt = m_cnt + 1'b1;
            end
        end
        lo  = m_lin ? m_base[BW-1:0] + m_cnt : m_base[BW-1:0] ^ m_cnt;
        ea  = {m_base[AW-1:BW], lo};
        s2v = s1v; s2d = s1d;
        s1v = (k == 1);
        if (k == 1) s1d = ref_mem[ea];
        if (k == 2)
            for (int l = 0; l < LANES; l++)
                if (msk[l]) ref_mem[ea][l*LANE_W +: LANE_W] = d_in[l*LANE_W +: LANE_W];
        g2 = g1; g1 = snooze;
    endtask

    task automatic chk(string tag, logic got_en, logic exp_en, logic [W-1:0] got_d, logic [W-1:0] exp_d);
        checks++;
        if (got_en !== exp_en || (exp_en && got_d !== exp_d)) begin
            errors++;
            $display("FAIL %s: q_en=%0b q_out=%h expected q_en=%0b q_out=%h",
                     tag, got_en, got_d, exp_en, exp_d);
        end
    endtask

    // inputs are set at a falling edge; check, then run one rising edge
    task automatic step(string tag);
        logic exp_en;
        #1;
        exp_en = s2v && !oe_n && !snooze && (kind_now() != 2);
        chk(tag, q_en, exp_en, q_out, s2d);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic drive(logic p, logic c, logic ce, logic c2, logic c2n, logic adv,
                         logic gw, logic bwe, logic [LANES-1:0] ln, logic [AW-1:0] a, logic [W-1:0] d);
        strb_p_n = p; strb_c_n = c; cen_n = ce; cen2 = c2; cen2_n = c2n; adv_n = adv;
        gwr_n = gw; bwe_n = bwe; lane_n = ln; addr = a; d_in = d;
    endtask

    task automatic idle(string tag);
        drive(1, 1, 0, 1, 0, 1, 1, 1, '1, '0, '0);
        step(tag);
    endtask

    task automatic c_write(logic [AW-1:0] a, logic [W-1:0] d, logic gw, logic bwe, logic [LANES-1:0] ln, string tag);
        drive(1, 0, 0, 1, 0, 1, gw, bwe, ln, a, d);
        step(tag);
    endtask

    task automatic c_read(logic [AW-1:0] a, string tag);
        drive(1, 0, 0, 1, 0, 1, 1, 1, '1, a, '0);
        step(tag);
    endtask

    task automatic p_start(logic [AW-1:0] a, logic gw, string tag);
        drive(0, 1, 0, 1, 0, 1, gw, 1, '1, a, pat(a, 77));
        step(tag);
    endtask

    task automatic cont(logic adv, logic gw, logic bwe, logic [LANES-1:0] ln, logic [W-1:0] d, string tag);
        drive(1, 1, 0, 1, 0, adv, gw, bwe, ln, '0, d);
        step(tag);
    endtask

    task automatic do_reset();
        drive(1, 1, 0, 1, 0, 1, 1, 1, '1, '0, '0);
        rst = 1'b1;
        @(posedge clk);
        m_act = 1'b0; s1v = 1'b0; s2v = 1'b0; g1 = 1'b0; g2 = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset", q_en, 1'b0, q_out, '0);
        do_reset();

        // R2 R4: fill every address with global writes
        for (int a = 0; a < DEPTH; a++) c_write(AW'(a), pat(a, 0), 0, 1, '1, "R2 fill");
        // R7 R8: back-to-back reads of every address
        for (int a = 0; a < DEPTH; a++) c_read(AW'(a), "R7 sweep");
        idle("R7 tail");
        idle("R8 drop");
        idle("R8 quiet");

        // R4: lane writes, empty mask, and lane selects without bwe_n
        for (int a = 0; a < 16; a++) c_write(AW'(a), pat(a, 1), 1, 0, LANES'(~(a % 4)), "R4 lanes");
        c_write(AW'(20), pat(20, 5), 1, 1, '0, "R4 bwe high");
        for (int a = 0; a < 21; a++) c_read(AW'(a), "R4 readback");
        idle("R4 tail"); idle("R4 tail");

        // R1 R5: processor start with write asserted, then follow-on write
        for (int a = 24; a < 32; a++) begin
            p_start(AW'(a), 0, "R1 pstart");
            cont(1, 1, 0, LANES'(~(a % 3 + 1)), pat(a, 2), "R5 follow write");
        end
        for (int a = 24; a < 32; a++) c_read(AW'(a), "R5 readback");
        idle("R5 tail"); idle("R5 tail");

        // R2 deselect, then processor strobe with cen_n high does nothing
        c_read(AW'(3), "R2 read");
        drive(1, 0, 1, 1, 0, 1, 1, 1, '1, AW'(3), '0); step("R2 deselect");
        drive(0, 1, 1, 1, 0, 1, 0, 1, '1, AW'(4), pat(4, 66)); step("R1 ignored");
        idle("R8 after deselect");
        c_read(AW'(4), "R1 unchanged");
        idle("R1 tail"); idle("R1 tail");

        // R6: every base offset in both orders, with a suspend and select noise
        for (int lm = 0; lm < 2; lm++) begin
            for (int b = 0; b < 4; b++) begin
                lin_mode = lm[0];
                p_start(AW'(32 + b), 1, "R6 start");
                lin_mode = ~lm[0];
                cont(0, 1, 1, '1, '0, "R6 step1");
                cont(1, 1, 1, '1, '0, "R6 hold");
                drive(1, 1, 1, 0, 1, 0, 1, 1, '1, '0, '0); step("R6 step2 sel off");
                cont(0, 1, 1, '1, '0, "R6 step3");
            end
        end
        idle("R6 tail"); idle("R6 tail");

        // R6: write burst in linear order, then read it back
        lin_mode = 1'b1;
        c_write(AW'(41), pat(41, 3), 0, 1, '1, "R6 wburst");
        for (int i = 1; i < 4; i++) cont(0, 0, 1, '1, pat(41 + i, 3), "R6 wburst");
        lin_mode = 1'b1;
        p_start(AW'(41), 1, "R6 rburst");
        for (int i = 1; i < 4; i++) cont(0, 1, 1, '1, '0, "R6 rburst");
        lin_mode = 1'b0;
        idle("R6 tail"); idle("R6 tail");

        // R3: secondary selects off on a load end the burst
        c_read(AW'(8), "R3 pre");
        drive(1, 0, 0, 0, 0, 1, 1, 1, '1, AW'(9), '0); step("R3 cen2 low");
        cont(0, 1, 1, '1, '0, "R3 no continue");
        cont(0, 0, 1, '1, pat(9, 44), "R3 no write");
        idle("R3 quiet");
        drive(0, 1, 0, 1, 1, 1, 1, 1, '1, AW'(10), '0); step("R3 cen2_n high");
        cont(1, 1, 1, '1, '0, "R3 no continue");
        idle("R3 quiet");
        c_read(AW'(9), "R3 unchanged");
        idle("R3 tail"); idle("R3 tail");

        // R9: oe_n gating and write suppression
        c_read(AW'(12), "R9 read");
        cont(1, 1, 1, '1, '0, "R9 hold read");
        oe_n = 1'b1;
        cont(1, 1, 1, '1, '0, "R9 oe high");
        oe_n = 1'b0;
        cont(1, 0, 1, '1, pat(12, 8), "R9 write hides drive");
        idle("R9 after write");
        idle("R9 quiet");
        c_read(AW'(12), "R9 readback");
        idle("R9 tail"); idle("R9 tail");

        // R11: reset mid burst
        p_start(AW'(16), 1, "R11 start");
        cont(0, 1, 1, '1, '0, "R11 step");
        do_reset();
        cont(0, 1, 1, '1, '0, "R11 no burst");
        idle("R11 quiet");
        idle("R11 quiet");

        // R10: snooze entry and exit windows
        c_write(AW'(5), pat(5, 9), 0, 1, '1, "R10 setup");
        c_read(AW'(5), "R10 read before");
        snooze = 1'b1;
        idle("R10 hidden");
        idle("R10 entering");
        c_write(AW'(5), pat(5, 90), 0, 1, '1, "R10 ignored");
        c_write(AW'(5), pat(5, 91), 0, 1, '1, "R10 ignored");
        c_read(AW'(5), "R10 ignored read");
        snooze = 1'b0;
        c_write(AW'(5), pat(5, 92), 0, 1, '1, "R10 exit window");
        c_read(AW'(5), "R10 exit window");
        idle("R10 quiet");
        c_read(AW'(5), "R10 retained");
        idle("R10 tail"); idle("R10 tail");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule